// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models a synchronous cache SRAM with flow-through reads and a four-beat burst address sequencer. On each rising clock edge it samples two active-low address strobes, a burst-advance input, three chip enables, a set of write controls and the address. From these it classifies the cycle as a deselect, a new read, a new write, a burst continue or a burst suspend. The array word is split into byte lanes that can be written on their own or all together.

Read data is not pipelined: the address captured at an edge selects the array word, and that word reaches the bus pads during the cycle that follows the same edge. The pads are described by a data-out vector and a drive-enable; the drive-enable goes high only for a selected read cycle while the asynchronous output-enable input is low. A static mode input chooses linear or interleaved burst order. The depth, byte width, byte count and burst length are parameters.

The processor strobe takes priority over the controller strobe, but only while enable A is low. The controller strobe deselects the device whenever the enables are not all met.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the device is deselected: `dq_oe` is 0 and no burst is active until a strobe is accepted.
- R2: An accepted strobe whose enables are not all met (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 is the only enabled combination) deselects the device, so `dq_oe` is 0 in the very next cycle.
- R3: A processor strobe (`cpu_strobe_n`=0) sampled while `sel_a_n`=1 is ignored; with the controller strobe high the current burst simply continues as if no strobe were present.
- R4: An accepted processor strobe always starts a read at the external address, even when the write inputs request a write, and the array is not modified.
- R5: An accepted strobe aborts an ongoing burst and restarts at the newly sampled external address.
- R6: With both strobes high and `adv_n`=0 the low two address bits step through the burst: linear order (`interleave`=0) gives start+k mod 4, interleaved order (`interleave`=1) gives start XOR k, for beat k = 1, 2, 3, wrapping after four beats.
- R7: With both strobes high and `adv_n`=1 the address is held and the burst is suspended.
- R8: `wr_all_n`=0 writes every byte lane of the addressed word from `dq_i`, whatever `wr_n` and `byte_wr_n` are.
- R9: With `wr_all_n`=1 and `wr_n`=0, lane i (bits 9i+8:9i of the word) is written only when `byte_wr_n[i]`=0. If no lane is selected, or `wr_n`=1, the cycle is a read.
- R10: Reads are flow-through: the word at the address sampled at an edge is on `dq_o` with `dq_oe`=1 during the cycle right after that edge.
- R11: `dq_oe` follows `out_en_n` without a clock (high `out_en_n` forces 0), and `dq_oe` is never 1 during a write cycle.
- R12: While deselected, cycles with both strobes high keep the device deselected and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip enable A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip enable B, active high |
| sel_c_n | input | 1 | Chip enable C, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_n | input | 1 | Lane write qualifier, active low |
| byte_wr_n | input | NBYTES | Per-lane write select, active low |
| interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_i | input | NBYTES*BYTE_W | Write data from the bus pads |
| dq_o | output | NBYTES*BYTE_W | Read data toward the bus pads |
| dq_oe | output | 1 | Bus pad drive enable |

## Verification
A wrong selected flag or cycle type shows at the pads within one cycle, as a drive-enable that is on during a write or a deselect, or off during a read. A wrong burst counter or base shows one cycle after the bad edge as the wrong word on `dq_o`. A lost write only shows later, when the same word is read back. The bench therefore fills a four-word block through a wrapping write burst and then reads it back in several orders. This covers suspend, ignored strobes, deselects and lane writes, so that each state error is exposed at the next read of the affected word.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START_RD,
    CYC_START_WR,
    CYC_CONT,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               interleave_i,
  input  logic [BURST_W-1:0] load_lo_i,
  output logic [BURST_W-1:0] nxt_lo_o
);
  logic [BURST_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               upd_en;

  always_comb begin
    upd_en = load_i | step_i;
    if (load_i) begin
      base_d = load_lo_i;
      cnt_d  = '0;
    end else begin
      base_d = base_q;
      cnt_d  = step_i ? cnt_q + 1'b1 : cnt_q;
    end
    nxt_lo_o = interleave_i ? (base_d ^ cnt_d) : (base_d + cnt_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: an advance without a load moves the beat counter by one, wrapping
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7: no load and no advance leaves the burst position untouched
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> ($stable(cnt_q) && $stable(base_q)));
  // R5: a new start restarts the burst at the external low bits
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0 && base_q == $past(load_lo_i)));
endmodule

// File: rtl/wr_decode.sv
module wr_decode #(
  parameter int NBYTES = 2
) (
  input  logic              wr_all_n,
  input  logic              wr_n,
  input  logic [NBYTES-1:0] byte_wr_n,
  output logic [NBYTES-1:0] lane_we_o,
  output logic              any_we_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_we_o[g] = !wr_all_n || (!wr_n && !byte_wr_n[g]);
  end
  assign any_we_o = |lane_we_o;

  always_comb begin
    // R8: global write selects every lane
    assert_global_R8: assert (wr_all_n || (&lane_we_o));
    // R9: without global write and lane qualifier no lane is written
    assert_noqual_R9: assert (!(wr_all_n && wr_n) || (lane_we_o == '0));
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic [NBYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[g]) begin
        lane_mem[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
      end
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BYTE_W  = 9,
  parameter int NBYTES  = 2,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_strobe_n,
  input  logic                     ctl_strobe_n,
  input  logic                     adv_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     wr_all_n,
  input  logic                     wr_n,
  input  logic [NBYTES-1:0]        byte_wr_n,
  input  logic                     interleave,
  input  logic                     out_en_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] dq_i,
  output logic [NBYTES*BYTE_W-1:0] dq_o,
  output logic                     dq_oe
);
  localparam int WORD_W = NBYTES * BYTE_W;
  localparam int HI_W   = ADDR_W - BURST_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // cycle classification
  cyc_e              cyc;
  logic              chip_en, cpu_take;
  logic              sel_q, sel_d;
  logic              rd_q, rd_d;
  logic              wr_now;
  logic [ADDR_W-1:0] addr_q, eff_addr;
  logic [NBYTES-1:0] lane_we;
  logic              any_we;
  logic [BURST_W-1:0] nxt_lo;
  logic              seq_load, seq_step;
  logic [WORD_W-1:0] rdata;

  wr_decode #(.NBYTES(NBYTES)) u_wdec (
    .wr_all_n (wr_all_n),
    .wr_n     (wr_n),
    .byte_wr_n(byte_wr_n),
    .lane_we_o(lane_we),
    .any_we_o (any_we)
  );

  always_comb begin
    chip_en  = !sel_a_n && sel_b && !sel_c_n;
    cpu_take = !cpu_strobe_n && !sel_a_n;
    if (cpu_take) begin
      cyc = chip_en ? CYC_START_RD : CYC_DESEL;
    end else if (!ctl_strobe_n) begin
      if (!chip_en)    cyc = CYC_DESEL;
      else if (any_we) cyc = CYC_START_WR;
      else             cyc = CYC_START_RD;
    end else if (sel_q) begin
      cyc = adv_n ? CYC_HOLD : CYC_CONT;
    end else begin
      cyc = CYC_IDLE;
    end

    seq_load = (cyc == CYC_START_RD) || (cyc == CYC_START_WR);
    seq_step = (cyc == CYC_CONT);
    sel_d    = seq_load || (cyc == CYC_CONT) || (cyc == CYC_HOLD);
    wr_now   = any_we && ((cyc == CYC_START_WR) || (cyc == CYC_CONT) ||
                          (cyc == CYC_HOLD));
    rd_d     = sel_d && !wr_now;
    eff_addr = seq_load ? {addr[ADDR_W-1:BURST_W], nxt_lo}
                        : {addr_q[ADDR_W-1:BURST_W], nxt_lo};
  end

  burst_seq #(.BURST_W(BURST_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_i      (seq_load),
    .step_i      (seq_step),
    .interleave_i(interleave),
    .load_lo_i   (addr[BURST_W-1:0]),
    .nxt_lo_o    (nxt_lo)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rd_q  <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  addr_q <= '0;
    else if (sel_d)  addr_q <= eff_addr;
  end

  sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mem (
    .clk    (clk),
    .we_i   (lane_we & {NBYTES{wr_now}}),
    .waddr_i(eff_addr),
    .wdata_i(dq_i),
    .raddr_i(addr_q),
    .rdata_o(rdata)
  );

  // flow-through read path, asynchronous output enable
  assign dq_o  = rdata;
  assign dq_oe = sel_q && rd_q && !out_en_n && rst_n;

  // R2: controller strobe with an unmet enable (processor strobe not taken)
  assert_ctl_desel_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctl_strobe_n && (cpu_strobe_n || sel_a_n) && !(!sel_a_n && sel_b && !sel_c_n))
    |=> !sel_q);
  // R3: processor strobe under a high enable A leaves the selection alone
  assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cpu_strobe_n && sel_a_n && ctl_strobe_n) |=> (sel_q == $past(sel_q)));
  // R4: an accepted processor start is always a read
  assert_cpu_read_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cpu_strobe_n && !sel_a_n && sel_b && !sel_c_n) |=> (sel_q && rd_q));
  // R11: the bus is not driven in the cycle of a write
  assert_no_drive_wr_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_now |=> !dq_oe);
  // R12: idle cycles keep a deselected device deselected
  assert_idle_stays_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sel_q && cpu_strobe_n && ctl_strobe_n) |=> !sel_q);
endmodule

// File: tb/burst_sram_ctrl_test.sv
module burst_sram_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 18;

  typedef struct packed {
    logic          cpu_n, ctl_n, adv_n, sa_n, sb, sc_n, wall_n, wr_n;
    logic [1:0]    bw_n;
    logic          oe_n;
    logic [AW-1:0] addr;
    logic          drv;
    logic [DW-1:0] wd;
    logic          eoe;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } vec_t;

  // cpu ctl adv sa sb sc wall wr bw oe addr drv wd eoe ed req
  localparam vec_t TBL [22] = '{
    '{1,0,1,0,1,0, 0,1,3,0, 8'h10, 1,18'h12345, 0,18'h0, 8},     // R8 start write all lanes
    '{1,1,0,0,1,0, 0,1,3,0, 8'h00, 1,18'h0F0F0, 0,18'h0, 6},     // R6 burst write 0x11
    '{1,1,0,0,1,0, 0,1,3,0, 8'h00, 1,18'h2AAAA, 0,18'h0, 6},     // R6 0x12
    '{1,1,0,0,1,0, 0,1,3,0, 8'h00, 1,18'h15555, 0,18'h0, 6},     // R6 0x13
    '{1,1,0,0,1,0, 0,1,3,0, 8'h00, 1,18'h3C3C3, 0,18'h0, 6},     // R6 wrap to 0x10
    '{0,1,1,0,1,0, 0,0,0,0, 8'h12, 1,18'h00777, 1,18'h2AAAA, 4}, // R4 cpu start is a read
    '{1,1,0,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h15555, 6},     // R6 0x13
    '{1,1,0,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h3C3C3, 6},     // R6 wrap 0x10
    '{1,1,1,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h3C3C3, 7},     // R7 suspend
    '{1,1,0,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h0F0F0, 6},     // R6 0x11
    '{1,1,1,0,1,0, 1,1,3,1, 8'h00, 0,18'h0, 0,18'h0, 11},        // R11 oe high
    '{1,1,1,0,1,0, 1,0,2,0, 8'h00, 1,18'h386AA, 0,18'h0, 11},    // R11 lane 0 write, no drive
    '{1,1,1,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h0F0AA, 9},     // R9 only lane 0 changed
    '{1,1,1,0,1,0, 1,0,3,0, 8'h00, 1,18'h3FFFF, 1,18'h0F0AA, 9}, // R9 no lane -> read
    '{0,1,0,1,1,0, 1,1,3,0, 8'h30, 0,18'h0, 1,18'h2AAAA, 3},     // R3 ignored, burst goes on
    '{1,0,1,0,0,0, 1,1,3,0, 8'h10, 0,18'h0, 0,18'h0, 2},         // R2 enable B low
    '{1,1,0,0,1,0, 0,1,3,0, 8'h13, 1,18'h3FFFF, 0,18'h0, 12},    // R12 idle write ignored
    '{1,0,1,0,1,0, 1,1,3,0, 8'h13, 0,18'h0, 1,18'h15555, 12},    // R12 0x13 intact
    '{1,0,1,0,1,0, 1,1,3,0, 8'h10, 0,18'h0, 1,18'h3C3C3, 5},     // R5 restart mid burst
    '{0,1,1,0,1,0, 1,1,3,0, 8'h11, 0,18'h0, 1,18'h0F0AA, 10},    // R10 flow-through
    '{1,0,1,0,1,1, 1,1,3,0, 8'h10, 0,18'h0, 0,18'h0, 2},         // R2 enable C high
    '{0,1,1,0,0,0, 1,1,3,0, 8'h10, 0,18'h0, 0,18'h0, 2}          // R2 cpu start, B low
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_strobe_n, ctl_strobe_n, adv_n, sel_a_n, sel_b, sel_c_n;
  logic          wr_all_n, wr_n, interleave, out_en_n;
  logic [1:0]    byte_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  burst_sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .interleave(interleave),
    .out_en_n(out_en_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [DW:0] act,
                     input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual oe/data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_n = 1; byte_wr_n = 2'b11; out_en_n = 0; addr = '0; dq_i = '0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    cpu_strobe_n = v.cpu_n; ctl_strobe_n = v.ctl_n; adv_n = v.adv_n;
    sel_a_n = v.sa_n; sel_b = v.sb; sel_c_n = v.sc_n;
    wr_all_n = v.wall_n; wr_n = v.wr_n; byte_wr_n = v.bw_n; out_en_n = v.oe_n;
    addr = v.addr; dq_i = v.drv ? v.wd : '0;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_bus(input bit eoe, input logic [DW-1:0] ed, input string req);
    chk((dq_oe == eoe) && (!eoe || dq_o == ed), req, {dq_oe, dq_o}, {eoe, ed});
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    interleave = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    expect_bus(0, '0, "R1 in reset");
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    expect_bus(0, '0, "R1 after release");

    // table walk, linear order
    for (int i = 0; i < 22; i++) begin
      apply(TBL[i]);
      expect_bus(TBL[i].eoe, TBL[i].ed, $sformatf("R%0d vec %0d", TBL[i].req, i));
    end

    // R6 interleaved order from low bits 01: 01,00,11,10
    @(negedge clk);
    interleave = 1;
    apply('{0,1,1,0,1,0, 1,1,3,0, 8'h11, 0,18'h0, 1,18'h0F0AA, 6});
    expect_bus(1, 18'h0F0AA, "R6 interleave beat0");
    apply('{1,1,0,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h3C3C3, 6});
    expect_bus(1, 18'h3C3C3, "R6 interleave beat1");
    apply('{1,1,0,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h15555, 6});
    expect_bus(1, 18'h15555, "R6 interleave beat2");
    apply('{1,1,0,0,1,0, 1,1,3,0, 8'h00, 0,18'h0, 1,18'h2AAAA, 6});
    expect_bus(1, 18'h2AAAA, "R6 interleave beat3");

    // R11 output enable acts without a clock edge
    @(negedge clk);
    adv_n = 1;
    out_en_n = 1;
    #0.5;
    expect_bus(0, '0, "R11 async disable");
    out_en_n = 0;
    #0.5;
    expect_bus(1, 18'h2AAAA, "R11 async enable");

    // R1 reset during an active burst
    rst_n = 0;
    #0.5;
    expect_bus(0, '0, "R1 reset mid burst");
    @(negedge clk);
    idle_inputs();
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    expect_bus(0, '0, "R1 no burst after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule